// File: doc/BRIEF.md
# Receive Digital Volume Scaler

This block sits in a voice receive path and scales each incoming 13-bit two's-complement audio sample by a gain selected from a 3-bit volume code that arrives in the same received word as the sample. The gain runs in 3 dB steps from +3 dB down to -18 dB. Each step is a fixed-point constant with 12 fractional bits. The product is rounded to nearest and then arithmetically shifted back to sample scale. The +3 dB step can push a sample past the 13-bit range, so the result is clamped.

A mode input chooses between linear operation, where the volume code takes effect, and companded operation, where the gain is held at unity whatever the code says. A mute input forces the output to zero and overrides any gain. The result is registered: it appears one clock after the sample-valid strobe, and the output valid flag is delayed to match.

Top module: `rxv_scaler`

## Requirements
- R1: `valid_o` is high in exactly the cycle that follows each clock edge where `valid_i` was high, and low in every other cycle.
- R2: In linear mode (`lin_en_i`=1, `mute_i`=0) the output is floor((s*C + 2048)/4096), where s is the input sample and C is looked up by the code on `vol_i`: 0→5786 (+3 dB), 1→4096 (0 dB), 2→2900, 3→2053, 4→1453, 5→1029, 6→728, 7→516 (-18 dB).
- R3: In companded mode (`lin_en_i`=0, `mute_i`=0) the output equals the input sample exactly, for every value of `vol_i`.
- R4: Each sample is scaled by the code presented with that same sample. A different code on back-to-back valid cycles changes the gain from one sample to the next.
- R5: A scaled result above 4095 is output as 4095, and a result below -4096 is output as -4096.
- R6: When `mute_i`=1 together with `valid_i`=1, the output sample is 0 in either mode and for any code or input sample.
- R7: While `valid_i` is low, `sample_o` keeps the value it last took.
- R8: After reset, `valid_o` is 0 and `sample_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| sample_i | input | 13 | Received sample, two's complement |
| vol_i | input | 3 | Volume code carried with the sample |
| lin_en_i | input | 1 | 1 = linear mode, 0 = companded mode |
| mute_i | input | 1 | Forces a zero output |
| valid_o | output | 1 | Output sample strobe |
| sample_o | output | 13 | Scaled sample, two's complement |

## Verification
Every result is due one clock after its strobe. The bench drives each input on the falling edge, waits for the next rising edge, and checks `valid_o` and `sample_o` one nanosecond later against a value computed by a bench function from the coefficient list in R2. Idle cycles are checked at the same point: the bench expects `valid_o` low and `sample_o` equal to the last expected value. Random traffic mixes valid and idle cycles, all codes, both modes and mute, and it is preceded by directed cases at the range limits.

// File: rtl/rxv_pkg.sv
package rxv_pkg;
  localparam int FRAC_W = 12;
  localparam int COEF_W = 14;
  localparam int VOL_W  = 3;
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1 << FRAC_W);

  // Q12 gain per 3 dB step, code 0 = +3 dB
  function automatic logic [COEF_W-1:0] gain_coef(input logic [VOL_W-1:0] code);
    case (code)
      3'd0:    return COEF_W'(5786);
      3'd1:    return COEF_W'(4096);
      3'd2:    return COEF_W'(2900);
      3'd3:    return COEF_W'(2053);
      3'd4:    return COEF_W'(1453);
      3'd5:    return COEF_W'(1029);
      3'd6:    return COEF_W'(728);
      default: return COEF_W'(516);
    endcase
  endfunction
endpackage

// File: rtl/rxv_gain_sel.sv
module rxv_gain_sel
  import rxv_pkg::*;
(
  input  logic [VOL_W-1:0]  vol_i,
  input  logic              lin_en_i,
  output logic [COEF_W-1:0] coef_o
);
  always_comb begin
    if (lin_en_i) coef_o = gain_coef(vol_i);
    else          coef_o = UNITY;
  end
endmodule

// File: rtl/rxv_mult_round.sv
module rxv_mult_round
  import rxv_pkg::*;
#(
  parameter int DATA_W = 13,
  localparam int PROD_W = DATA_W + COEF_W + 2
) (
  input  logic signed [DATA_W-1:0] din_i,
  input  logic        [COEF_W-1:0] coef_i,
  output logic signed [PROD_W-1:0] q_o
);
  localparam logic signed [PROD_W-1:0] RND = PROD_W'(1) << (FRAC_W - 1);

  logic signed [PROD_W-1:0] a_ext, c_ext, prod, biased;

  always_comb begin
    a_ext  = PROD_W'(din_i);
    c_ext  = PROD_W'($signed({1'b0, coef_i}));
    prod   = a_ext * c_ext;
    biased = prod + RND;
    q_o    = biased >>> FRAC_W;
  end
endmodule

// File: rtl/rxv_sat.sv
module rxv_sat #(
  parameter int IN_W  = 29,
  parameter int OUT_W = 13
) (
  input  logic signed [IN_W-1:0]  din_i,
  output logic signed [OUT_W-1:0] dout_o
);
  localparam logic signed [IN_W-1:0] MAXV = IN_W'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [IN_W-1:0] MINV = -MAXV - IN_W'(1);

  generate
    if (IN_W > OUT_W) begin : g_clamp
      always_comb begin
        if (din_i > MAXV)      dout_o = OUT_W'(MAXV);
        else if (din_i < MINV) dout_o = OUT_W'(MINV);
        else                   dout_o = OUT_W'(din_i);
      end
    end else begin : g_pass
      assign dout_o = OUT_W'(din_i);
    end
  endgenerate
endmodule

// File: rtl/rxv_scaler.sv
module rxv_scaler
  import rxv_pkg::*;
#(
  parameter int DATA_W = 13
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic        [VOL_W-1:0]  vol_i,
  input  logic                     lin_en_i,
  input  logic                     mute_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] sample_o
);
  localparam int PROD_W = DATA_W + COEF_W + 2;

  logic        [COEF_W-1:0] coef;
  logic signed [PROD_W-1:0] scaled;
  logic signed [DATA_W-1:0] clamped;
  logic signed [DATA_W-1:0] nxt;

  rxv_gain_sel u_sel (
    .vol_i    (vol_i),
    .lin_en_i (lin_en_i),
    .coef_o   (coef)
  );

  rxv_mult_round #(.DATA_W(DATA_W)) u_mul (
    .din_i  (sample_i),
    .coef_i (coef),
    .q_o    (scaled)
  );

  rxv_sat #(.IN_W(PROD_W), .OUT_W(DATA_W)) u_sat (
    .din_i  (scaled),
    .dout_o (clamped)
  );

  // mute overrides gain
  assign nxt = mute_i ? '0 : clamped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) sample_o <= nxt;
    end
  end

  // R1
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  vld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R3
  comp_unity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mute_i && !lin_en_i) |=> (sample_o == $past(sample_i)));
  // R6
  mute_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mute_i) |=> (sample_o == '0));
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sample_o));
endmodule

// File: tb/rxv_scaler_test.sv
module rxv_scaler_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic signed [12:0] smp = '0;
  logic [2:0] vol = '0;
  logic lin = 1'b1;
  logic mute = 1'b0;
  logic valid_q;
  logic signed [12:0] smp_q;

  int total = 0;
  int bad = 0;
  int exp_hold = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxv_scaler uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sample_i(smp),
    .vol_i(vol), .lin_en_i(lin), .mute_i(mute),
    .valid_o(valid_q), .sample_o(smp_q)
  );

  function automatic int coef_of(input int code);
    case (code)
      0: return 5786; 1: return 4096; 2: return 2900; 3: return 2053;
      4: return 1453; 5: return 1029; 6: return 728;  default: return 516;
    endcase
  endfunction

  function automatic int model(input int s, input int code, input bit l, input bit m);
    longint p;
    if (m) return 0;
    if (!l) return s;
    p = (longint'(s) * coef_of(code) + 2048) >>> 12;
    if (p > 4095) p = 4095;
    if (p < -4096) p = -4096;
    return int'(p);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input bit v, input int s, input int code,
                       input bit l, input bit m);
    int e;
    @(negedge clk);
    valid = v; smp = 13'(s); vol = 3'(code); lin = l; mute = m;
    e = v ? model(s, code, l, m) : exp_hold;
    @(posedge clk); #1;
    check({req, " valid"}, int'(valid_q), int'(v));
    check(req, int'(smp_q), e);
    exp_hold = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset valid", int'(valid_q), 0);
    check("R8 reset sample", int'(smp_q), 0);
    @(negedge clk) rst_n = 1'b1;

    // R2: every code on a positive and a negative sample
    for (int c = 0; c < 8; c++) apply("R2 pos", 1, 1000, c, 1, 0);
    for (int c = 0; c < 8; c++) apply("R2 neg", 1, -1777, c, 1, 0);
    apply("R2 minus one", 1, -1, 2, 1, 0);
    // R5: boost past the range
    apply("R5 clamp high", 1, 4095, 0, 1, 0);
    apply("R5 clamp low", 1, -4096, 0, 1, 0);
    apply("R5 edge", 1, 2896, 0, 1, 0);
    // R3: code ignored in companded mode
    apply("R3 comp code0", 1, 4095, 0, 0, 0);
    apply("R3 comp code7", 1, -4096, 7, 0, 0);
    apply("R3 comp mid", 1, 1234, 5, 0, 0);
    // R6: mute wins over boost
    apply("R6 mute lin", 1, 4095, 0, 1, 1);
    apply("R6 mute comp", 1, -300, 3, 0, 1);
    // R7: hold while idle, inputs changing
    apply("R2 load", 1, 800, 1, 1, 0);
    apply("R7 hold", 0, -4000, 0, 1, 0);
    apply("R7 hold mute", 0, 100, 7, 0, 1);
    apply("R1 resume", 1, 500, 4, 1, 0);
    // R4: code changes every sample
    apply("R4 seq a", 1, 2000, 0, 1, 0);
    apply("R4 seq b", 1, 2000, 7, 1, 0);
    apply("R4 seq c", 1, 2000, 3, 1, 0);

    for (int i = 0; i < 2000; i++) begin
      bit v = ($urandom % 4) != 0;
      int s = int'($urandom % 8192) - 4096;
      int c = int'($urandom % 8);
      bit l = ($urandom % 4) != 0;
      bit m = ($urandom % 10) == 0;
      apply("R1 R2 R3 R6 R7 rand", v, s, c, l, m);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule